// File: doc/BRIEF.md
# Time-Division Serial Link with In-Band Frame Marker

This block moves a parallel word across a single serial wire by giving each bit of the word its own time slot. A transmit side walks a slot counter across the word and drives one bit per clock onto the line. A receive side runs a matching counter that steers each incoming bit back into its place in a parallel output register. No select lines go with the data. Both ends share one clock, and their counters are kept in step in one of two ways: by a long stretch of constant high on the line, which the receiver uses to reset its counter, or by a direct restart input that sets both counters to the same phase.

Each frame opens with a marker of `SYNC_LEN` high slots. One low guard slot follows, and then one slot per channel. The marker is longer than any run of high bits the data can produce, so payload bits can never be taken for the marker. The transmitter freezes the input word for the whole data part of a frame. The receiver updates each output bit only in that bit's own slot and pulses a valid strobe when a frame is complete. The word rate must therefore stay well below the slot clock: at least one full frame must pass between changes of the input word.

Top module: `tdm_link`

## Requirements
- R1: The link carries `2**SEL_W` channels over one line (16 channels with the default `SEL_W` = 4). The transmit and receive slot selects are `SEL_W` bits wide.
- R2: A frame lasts `SYNC_LEN + 1 + 2**SEL_W` clocks (34 by default). `serialOut` is high for `SYNC_LEN` slots, low for one guard slot, and then carries `wordIn` bit i in data slot i, starting with bit 0. After reset the first frame starts in the first cycle.
- R3: `wordIn` is sampled once per frame, at the clock edge that ends the guard slot. Changes to it during the data slots do not affect the frame in progress.
- R4: The receiver synchronises when the line goes low after more than `2**SEL_W` consecutive high clocks. A run of exactly `2**SEL_W` highs followed by a low does not synchronise it.
- R5: Payload cannot imitate the marker. All-ones words are carried without loss of alignment, and `serialOut` is never high for more than `SYNC_LEN + 2**SEL_W` consecutive clocks.
- R6: Each bit of `wordOut` changes only in its own data slot, so at most one bit of `wordOut` changes per clock.
- R7: `frameValid` is high for exactly one clock, in the cycle after the last data slot has been captured. At that point `wordOut` holds the whole frame. In steady loopback, pulses are one frame length apart.
- R8: After reset, and until the first marker or restart, `wordOut` is zero and `frameValid` stays low.
- R9: A one-clock `restart` sets both slot counters to the start of a frame and marks the receiver as aligned, without any marker on the line. `serialOut` is high in the next cycle.
- R10: If the line delay changes, the receiver realigns at the next marker, and later words arrive intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared slot clock |
| rstN | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Direct counter alignment for both ends |
| wordIn | input | 2**SEL_W | Parallel word to send |
| serialOut | output | 1 | Transmit line |
| serialIn | input | 1 | Receive line |
| wordOut | output | 2**SEL_W | Recovered parallel word |
| frameValid | output | 1 | One-clock pulse when a frame is complete |

## Verification
Walking-one and walking-zero words sweep every channel. They show whether bits reach the right slot and the right output position, or get swapped or dropped. All-ones and all-zeros words probe the marker detector from both sides: the longest legal high run, and a line that never rises inside the data. A word changed in the middle of a frame separates per-frame latching from live sampling. A bench-driven line with 16 or 17 highs before the low pins the detection threshold exactly. A delayed loopback and a marker-free restart check realignment by the marker and by the direct input, each on its own.

// File: rtl/tdm_pkg.sv
`timescale 1ns/1ps
package tdm_pkg;
  // Strobes from the slot control to the datapath.
  typedef struct packed {
    logic txSync;     // line forced high (marker)
    logic txData;     // line carries the selected held bit
    logic txLoad;     // latch wordIn at end of guard slot
    logic rxCapture;  // write serialIn into wordOut[rxSel]
    logic rxLast;     // capture of the final channel
  } tdmStrobes_t;
endpackage

// File: rtl/tdm_ctrl.sv
`timescale 1ns/1ps
module tdm_ctrl
  import tdm_pkg::*;
#(
  parameter int SEL_W    = 4,
  parameter int SYNC_LEN = (1 << SEL_W) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic             serialIn,
  output tdmStrobes_t      strb,
  output logic [SEL_W-1:0] txSel,
  output logic [SEL_W-1:0] rxSel,
  output logic             locked
);
  localparam int CHANNELS  = 1 << SEL_W;
  localparam int FRAME_LEN = SYNC_LEN + 1 + CHANNELS;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam int RUN_W     = $clog2(CHANNELS + 2);
  localparam logic [CNT_W-1:0] GUARD_C = CNT_W'(SYNC_LEN);
  localparam logic [CNT_W-1:0] DATA_C  = CNT_W'(SYNC_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(FRAME_LEN - 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(CHANNELS + 1);

  logic [CNT_W-1:0] txCnt, rxCnt;
  logic [RUN_W-1:0] highRun;
  logic             syncSeen;

  // A low after more than CHANNELS highs can only be the guard slot.
  assign syncSeen = !serialIn && (highRun == RUN_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCnt   <= '0;
      rxCnt   <= '0;
      highRun <= '0;
      locked  <= 1'b0;
    end else if (restart) begin
      txCnt   <= '0;
      rxCnt   <= '0;
      highRun <= '0;
      locked  <= 1'b1;
    end else begin
      txCnt <= (txCnt == LAST_C) ? '0 : txCnt + 1'b1;
      if (!serialIn)               highRun <= '0;
      else if (highRun != RUN_MAX) highRun <= highRun + 1'b1;
      if (syncSeen) begin
        rxCnt  <= DATA_C;
        locked <= 1'b1;
      end else begin
        rxCnt <= (rxCnt == LAST_C) ? '0 : rxCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb           = '0;
    strb.txSync    = txCnt < GUARD_C;
    strb.txData    = txCnt >= DATA_C;
    strb.txLoad    = txCnt == GUARD_C;
    strb.rxCapture = locked && !syncSeen && !restart && (rxCnt >= DATA_C);
    strb.rxLast    = strb.rxCapture && (rxCnt == LAST_C);
    txSel          = strb.txData ? SEL_W'(txCnt - DATA_C) : '0;
    rxSel          = (rxCnt >= DATA_C) ? SEL_W'(rxCnt - DATA_C) : '0;
  end
endmodule

// File: rtl/tdm_datapath.sv
`timescale 1ns/1ps
module tdm_datapath
  import tdm_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  tdmStrobes_t              strb,
  input  logic [SEL_W-1:0]         txSel,
  input  logic [SEL_W-1:0]         rxSel,
  input  logic [(1 << SEL_W)-1:0]  wordIn,
  input  logic                     serialIn,
  output logic                     serialOut,
  output logic [(1 << SEL_W)-1:0]  wordOut,
  output logic                     frameValid
);
  localparam int CHANNELS = 1 << SEL_W;

  logic [CHANNELS-1:0] held;

  // Transmit: one word per frame, multiplexed by slot.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            held <= '0;
    else if (strb.txLoad) held <= wordIn;
  end

  assign serialOut = strb.txSync | (strb.txData & held[txSel]);

  // Receive: one register per channel, written only in its own slot.
  for (genvar g = 0; g < CHANNELS; g++) begin : g_demux
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                            wordOut[g] <= 1'b0;
      else if (strb.rxCapture && (rxSel == SEL_W'(g)))      wordOut[g] <= serialIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frameValid <= 1'b0;
    else       frameValid <= strb.rxLast;
  end
endmodule

// File: rtl/tdm_link.sv
`timescale 1ns/1ps
module tdm_link
  import tdm_pkg::*;
#(
  parameter int SEL_W    = 4,
  parameter int SYNC_LEN = (1 << SEL_W) + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    restart,
  input  logic [(1 << SEL_W)-1:0] wordIn,
  output logic                    serialOut,
  input  logic                    serialIn,
  output logic [(1 << SEL_W)-1:0] wordOut,
  output logic                    frameValid
);
  if (SYNC_LEN < (1 << SEL_W) + 1) begin : g_bad_sync
    $error("SYNC_LEN must exceed the channel count");
  end

  tdmStrobes_t      strb;
  logic [SEL_W-1:0] txSel, rxSel;
  logic             rxLocked;

  tdm_ctrl #(.SEL_W(SEL_W), .SYNC_LEN(SYNC_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .restart(restart), .serialIn(serialIn),
    .strb(strb), .txSel(txSel), .rxSel(rxSel), .locked(rxLocked)
  );

  tdm_datapath #(.SEL_W(SEL_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .txSel(txSel), .rxSel(rxSel),
    .wordIn(wordIn), .serialIn(serialIn), .serialOut(serialOut),
    .wordOut(wordOut), .frameValid(frameValid)
  );
endmodule

// File: rtl/tdm_link_chk.sv
`timescale 1ns/1ps
module tdm_link_chk #(
  parameter int SEL_W    = 4,
  parameter int SYNC_LEN = (1 << SEL_W) + 1
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    restart,
  input logic                    serialOut,
  input logic [(1 << SEL_W)-1:0] wordOut,
  input logic                    frameValid,
  input logic                    locked
);
  localparam int RUN_LIMIT = SYNC_LEN + (1 << SEL_W);
  localparam int RW        = $clog2(RUN_LIMIT + 2);
  localparam logic [RW-1:0] RUN_CAP = RW'(RUN_LIMIT + 1);

  logic [RW-1:0] txRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 txRun <= '0;
    else if (!serialOut)       txRun <= '0;
    else if (txRun != RUN_CAP) txRun <= txRun + 1'b1;
  end

  // R5: the line high run stays within marker plus one frame of ones
  a_r5_line_run: assert property (@(posedge clk) disable iff (!rstN)
    txRun <= RW'(RUN_LIMIT));

  // R6: at most one output bit moves per clock
  a_r6_one_bit: assert property (@(posedge clk) disable iff (!rstN)
    $countones(wordOut ^ $past(wordOut)) <= 1);

  // R7: frame strobe is a single clock wide
  a_r7_pulse: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> !frameValid);

  // R8: quiet outputs before alignment
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !locked |-> (wordOut == '0 && !frameValid));

  // R9: restart puts the transmitter at the marker
  a_r9_restart: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> serialOut);
endmodule

bind tdm_link tdm_link_chk #(.SEL_W(SEL_W), .SYNC_LEN(SYNC_LEN)) chk_i (
  .clk(clk), .rstN(rstN), .restart(restart), .serialOut(serialOut),
  .wordOut(wordOut), .frameValid(frameValid), .locked(rxLocked)
);

// File: tb/tdm_link_tb_top.sv
`timescale 1ns/1ps
module tdm_link_tb_top;
  localparam int SEL_W     = 4;
  localparam int CH        = 1 << SEL_W;
  localparam int SYNC_LEN  = CH + 1;
  localparam int FRAME_LEN = SYNC_LEN + 1 + CH;
  localparam int DLY       = 3;

  logic          clk = 1'b0, rstN = 1'b0, restart = 1'b0;
  logic [CH-1:0] wordIn = '0;
  logic          serialOut, serialIn, frameValid;
  logic [CH-1:0] wordOut;
  logic [1:0]    lineMode = 2'd0;
  logic          lineDrv = 1'b0;
  logic [DLY-1:0] dly = '0;

  int checks = 0, errors = 0;
  bit done = 0;
  bit multiBit;

  always #10 clk = ~clk;
  always @(posedge clk) dly <= {dly[DLY-2:0], serialOut};
  assign serialIn = (lineMode == 2'd0) ? serialOut :
                    (lineMode == 2'd1) ? dly[DLY-1] : lineDrv;

  tdm_link #(.SEL_W(SEL_W), .SYNC_LEN(SYNC_LEN)) dut_i (
    .clk(clk), .rstN(rstN), .restart(restart), .wordIn(wordIn),
    .serialOut(serialOut), .serialIn(serialIn), .wordOut(wordOut),
    .frameValid(frameValid)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic waitPulse(output int gap);
    logic [CH-1:0] prev;
    int n = 0;
    prev = wordOut;
    multiBit = 0;
    do begin
      @(negedge clk);
      n++;
      if ($countones(wordOut ^ prev) > 1) multiBit = 1;
      prev = wordOut;
    end while (!frameValid && n < 200);
    gap = n;
  endtask

  task automatic sendWord(input logic [CH-1:0] w, input bit chkGap);
    int gap;
    wordIn = w;
    waitPulse(gap);
    chk(wordOut == w, "R2 word", 32'(wordOut), 32'(w));
    chk(!multiBit, "R6 one bit per slot", 32'(multiBit), 32'd0);
    if (chkGap) chk(gap == FRAME_LEN, "R7 period", 32'(gap), 32'(FRAME_LEN));
  endtask

  task automatic driveBit(input logic b);
    lineDrv = b;
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int gap;
    logic [CH-1:0] pat;
    // Reset state (R8)
    wordIn = 16'h1234;
    repeat (2) @(negedge clk);
    chk(wordOut == '0 && !frameValid, "R8 reset", 32'(wordOut), 32'd0);
    rstN = 1'b1;
    // First frame layout in loopback (R1, R2, R8)
    for (int k = 0; k < FRAME_LEN; k++) begin
      logic expLine;
      expLine = (k < SYNC_LEN) ? 1'b1 : (k == SYNC_LEN) ? 1'b0 : wordIn[k - SYNC_LEN - 1];
      chk(serialOut == expLine, "R2 line slot", 32'(serialOut), 32'(expLine));
      chk(!frameValid, "R7 no early pulse", 32'(frameValid), 32'd0);
      if (k <= SYNC_LEN) chk(wordOut == '0, "R8 unlocked zero", 32'(wordOut), 32'd0);
      @(negedge clk);
    end
    chk(frameValid == 1'b1, "R7 first pulse", 32'(frameValid), 32'd1);
    chk(wordOut == 16'h1234, "R1 16 channels", 32'(wordOut), 32'h1234);
    // Sweeps: walking ones, walking zeros, extremes (R2, R5, R6, R7)
    for (int i = 0; i < CH; i++) sendWord(CH'(1) << i, 1);
    for (int i = 0; i < CH; i++) sendWord(~(CH'(1) << i), 1);
    sendWord('1, 1);
    sendWord('1, 1);
    sendWord('0, 1);
    sendWord('1, 1);
    sendWord(16'hA5C3, 1); // R5: aligned after all-ones runs
    // Mid-frame change ignored (R3)
    wordIn = 16'h0F0F;
    repeat (20) @(negedge clk);
    wordIn = 16'hF00F;
    waitPulse(gap);
    chk(wordOut == 16'h0F0F, "R3 frozen word", 32'(wordOut), 32'h0F0F);
    waitPulse(gap);
    chk(wordOut == 16'hF00F, "R3 next frame", 32'(wordOut), 32'hF00F);
    // Delayed line: realign on marker (R10)
    lineMode = 2'd1;
    repeat (3) waitPulse(gap);
    sendWord(16'h6E2B, 1);
    sendWord(16'h8001, 1);
    lineMode = 2'd0;
    repeat (3) waitPulse(gap);
    sendWord(16'h3C5A, 1);
    // Threshold on a bench-driven line (R4)
    lineMode = 2'd2;
    lineDrv = 1'b0;
    doReset();
    repeat (CH) driveBit(1'b1);
    driveBit(1'b0);
    repeat (CH) driveBit(1'b1);
    driveBit(1'b0);
    for (int k = 0; k < 20; k++) begin
      chk(!frameValid && wordOut == '0, "R4 short run ignored", 32'(wordOut), 32'd0);
      driveBit(1'b0);
    end
    pat = 16'hC3A5;
    repeat (CH + 1) driveBit(1'b1);
    driveBit(1'b0);
    for (int i = 0; i < CH; i++) driveBit(pat[i]);
    chk(frameValid == 1'b1, "R4 sync pulse", 32'(frameValid), 32'd1);
    chk(wordOut == pat, "R4 sync word", 32'(wordOut), 32'(pat));
    // Direct restart with no marker on the line (R9)
    lineDrv = 1'b0;
    doReset();
    repeat (5) @(negedge clk);
    chk(wordOut == '0 && !frameValid, "R8 no sync yet", 32'(wordOut), 32'd0);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    chk(serialOut == 1'b1, "R9 tx at marker", 32'(serialOut), 32'd1);
    pat = 16'h5B17;
    repeat (SYNC_LEN + 1) driveBit(1'b0);
    for (int i = 0; i < CH; i++) driveBit(pat[i]);
    chk(frameValid == 1'b1, "R9 pulse", 32'(frameValid), 32'd1);
    chk(wordOut == pat, "R9 word", 32'(wordOut), 32'(pat));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule